// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Master

This block generates the time slots of a single-wire, open-drain bus. It can issue a bus reset with presence detection, a write-0 slot, or a write-1 slot. A write-1 slot also serves as a read: the line is sampled at a fixed point in the slot. All timing is counted in units. One unit is `CLK_DIV` clocks multiplied by a runtime coefficient. With the coefficient at 1 and `CLK_DIV` set to the number of clocks per microsecond, the unit is one microsecond.

A command names an operation and carries an eight-bit data word. The bit operation runs one slot. The byte operation runs eight back-to-back slots, least significant bit first, and assembles the sampled bits into a byte. The reset operation runs the reset/presence sequence. The block raises a busy flag while it works. It pulses a done strobe for one clock when the command completes, and it presents the result on a data output that holds until the next completion. The block never drives the line high. It only enables a low driver or releases the line. The returning line level passes through a two-stage synchronizer before it is sampled.

Top module: `owire_slot_master`

## Requirements
- R1: Op code `00` is a single bit slot whose kind is set by `cmd_data_i[0]`. When that bit is 1, the line is driven low for 6 units and the whole command keeps `busy_o` high for 70 units plus one clock. `rdata_o` returns the sampled line level in bit 0, with zeros above it.
- R2: A bit slot with `cmd_data_i[0]` = 0 drives the line low for 60 units and lasts 70 units plus one clock. It returns `rdata_o` = 0 whatever the line does.
- R3: Op codes `10` and `11` run a bus reset. The line is driven low for 480 units and the command lasts 960 units plus one clock. The line is sampled 70 units after release. `rdata_o` is 0 when a device holds the line low there (presence) and 1 when nothing answers.
- R4: In a 1-slot, the line is sampled 9 units after release, through the synchronizer. A device that releases the line well before that point reads as 1. A device that still holds the line low past that point reads as 0.
- R5: Op code `01` runs eight slots, least significant bit of `cmd_data_i` first. Each 1 bit gives a 6-unit low pulse and each 0 bit gives a 60-unit low pulse. The command lasts 8 × (70 units + 1 clock). The sampled bits form `rdata_o` least significant bit first, so writing `0xFF` reads a byte. `rdata_o` changes only in the cycle in which `done_o` is high.
- R6: One unit is `CLK_DIV` × `coef_i` clocks, and a `coef_i` of 0 behaves as 1. The coefficient is captured when each slot starts, so a change to it during a slot does not alter that slot.
- R7: A command is accepted when `cmd_valid_i` is high and `busy_o` is low. Commands presented while `busy_o` is high are ignored. `done_o` is high for exactly one clock, in the cycle where `busy_o` has just fallen.
- R8: After reset, `drive_low_o` = 0, `busy_o` = 0, `done_o` = 0 and `rdata_o` = 0.
- R9: `drive_low_o` is asserted only while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_i | input | COEF_W | Slot duration multiplier (0 acts as 1) |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 00 bit slot, 01 byte, 1x bus reset |
| cmd_data_i | input | DATA_W | Bit value in bit 0, or byte to send |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-clock completion strobe |
| rdata_o | output | DATA_W | Sampled bit, presence result or assembled byte |
| line_i | input | 1 | Bus line level (asynchronous) |
| drive_low_o | output | 1 | Open-drain low enable |

## Verification
The hardest behaviour to reach from the ports is the sample instant itself. It only shows when a device on the bus holds the line low for a chosen time after the master releases it. The bench therefore models a device that counts clocks from each release and pulls the line for a programmed hold time, or for each slot follows a byte pattern. Hold times placed a few clocks on either side of the 9-unit and 70-unit sample points show that the sample lands in the intended window, after the synchronizer delay. The same model also supplies the presence answer and the bits of a byte read.

// File: rtl/owire_pkg.sv
package owire_pkg;
  localparam int CNT_W = 9;

  typedef enum logic [1:0] {SLOT_RESET, SLOT_ZERO, SLOT_ONE} slot_e;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_PRE, PH_POST} phase_e;

  localparam logic [1:0] OP_BIT  = 2'b00;
  localparam logic [1:0] OP_BYTE = 2'b01;

  // units per phase: low, release-to-sample, sample-to-end
  function automatic logic [CNT_W-1:0] phase_len(slot_e k, phase_e p);
    logic [CNT_W-1:0] r;
    r = CNT_W'(1);
    unique case (k)
      SLOT_RESET: case (p)
        PH_LOW:  r = CNT_W'(480);
        PH_PRE:  r = CNT_W'(70);
        PH_POST: r = CNT_W'(410);
        default: r = CNT_W'(1);
      endcase
      SLOT_ZERO: case (p)
        PH_LOW:  r = CNT_W'(60);
        PH_PRE:  r = CNT_W'(5);
        PH_POST: r = CNT_W'(5);
        default: r = CNT_W'(1);
      endcase
      default: case (p)
        PH_LOW:  r = CNT_W'(6);
        PH_PRE:  r = CNT_W'(9);
        PH_POST: r = CNT_W'(55);
        default: r = CNT_W'(1);
      endcase
    endcase
    return r;
  endfunction

  function automatic slot_e bit_kind(logic b);
    return b ? SLOT_ONE : SLOT_ZERO;
  endfunction
endpackage

// File: rtl/owire_unit_tick.sv
module owire_unit_tick #(
  parameter int CLK_DIV = 50,
  parameter int COEF_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              unit_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0]  div_q;
  logic [COEF_W-1:0] rep_q, coef_q;
  logic              div_wrap;

  assign div_wrap = (div_q == DIV_LAST);
  assign unit_o   = div_wrap && (rep_q == coef_q - COEF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      rep_q  <= '0;
      coef_q <= COEF_W'(1);
    end else if (restart_i) begin
      div_q  <= '0;
      rep_q  <= '0;
      coef_q <= (coef_i == '0) ? COEF_W'(1) : coef_i;
    end else if (div_wrap) begin
      div_q <= '0;
      rep_q <= unit_o ? '0 : rep_q + COEF_W'(1);
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
  import owire_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  slot_e kind_i,
  input  logic  unit_i,
  input  logic  line_i,
  output logic  drive_low_o,
  output logic  done_o,
  output logic  bit_o
);
  phase_e           ph_q;
  slot_e            kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last        = unit_i && (cnt_q == phase_len(kind_q, ph_q) - CNT_W'(1));
  assign drive_low_o = (ph_q == PH_LOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      kind_q <= SLOT_ONE;
      cnt_q  <= '0;
      done_o <= 1'b0;
      bit_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (ph_q == PH_IDLE) begin
        if (start_i) begin
          ph_q   <= PH_LOW;
          kind_q <= kind_i;
          cnt_q  <= '0;
        end
      end else if (unit_i) begin
        if (last) begin
          cnt_q <= '0;
          unique case (ph_q)
            PH_LOW: ph_q <= PH_PRE;
            PH_PRE: begin
              ph_q  <= PH_POST;
              bit_o <= (kind_q == SLOT_ZERO) ? 1'b0 : line_i;
            end
            default: begin
              ph_q   <= PH_IDLE;
              done_o <= 1'b1;
            end
          endcase
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/owire_byte_ctrl.sv
module owire_byte_ctrl
  import owire_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              eng_done_i,
  input  logic              eng_bit_i,
  output logic              slot_start_o,
  output slot_e             slot_kind_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int CW = $clog2(DATA_W);

  logic              active_q, byte_q;
  logic [DATA_W-1:0] sh_q, gathered;
  logic [CW-1:0]     left_q;
  logic              accept, more;

  assign accept       = cmd_valid_i && !active_q;
  assign more         = active_q && eng_done_i && byte_q && (left_q != '0);
  assign slot_start_o = accept || more;
  assign gathered     = {eng_bit_i, sh_q[DATA_W-1:1]};
  assign busy_o       = active_q;

  always_comb begin
    if (accept) slot_kind_o = cmd_op_i[1] ? SLOT_RESET : bit_kind(cmd_data_i[0]);
    else        slot_kind_o = bit_kind(sh_q[1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      byte_q   <= 1'b0;
      sh_q     <= '0;
      left_q   <= '0;
      done_o   <= 1'b0;
      rdata_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        active_q <= 1'b1;
        byte_q   <= (cmd_op_i == OP_BYTE);
        sh_q     <= cmd_data_i;
        left_q   <= CW'(DATA_W - 1);
      end else if (active_q && eng_done_i) begin
        sh_q <= gathered;
        if (more) begin
          left_q <= left_q - CW'(1);
        end else begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
          rdata_o  <= byte_q ? gathered : {{(DATA_W-1){1'b0}}, eng_bit_i};
        end
      end
    end
  end
endmodule

// File: rtl/owire_slot_master.sv
module owire_slot_master
  import owire_pkg::*;
#(
  parameter int CLK_DIV = 50,
  parameter int COEF_W  = 4,
  parameter int DATA_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              line_i,
  output logic              drive_low_o
);
  logic  slot_start, unit, line_s, eng_done, eng_bit;
  slot_e slot_kind;

  owire_sync #(.STAGES(SYNC_N)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  owire_unit_tick #(.CLK_DIV(CLK_DIV), .COEF_W(COEF_W)) i_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(slot_start),
    .coef_i   (coef_i),
    .unit_o   (unit)
  );

  owire_slot_engine i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (slot_start),
    .kind_i     (slot_kind),
    .unit_i     (unit),
    .line_i     (line_s),
    .drive_low_o(drive_low_o),
    .done_o     (eng_done),
    .bit_o      (eng_bit)
  );

  owire_byte_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_data_i  (cmd_data_i),
    .eng_done_i  (eng_done),
    .eng_bit_i   (eng_bit),
    .slot_start_o(slot_start),
    .slot_kind_o (slot_kind),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/owire_slot_checker.sv
module owire_slot_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              drive_low_o,
  input logic [DATA_W-1:0] rdata_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_BUSY_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o); // R7
  AST_DRIVE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_low_o |-> busy_o); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o)); // R5
endmodule

bind owire_slot_master owire_slot_checker #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .drive_low_o(drive_low_o),
  .rdata_o    (rdata_o)
);

// File: tb/test_owire_slot_master.sv
module test_owire_slot_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic       clk_i = 0, rst_ni = 0;
  logic [3:0] coef_i = 4'd1;
  logic       cmd_valid_i = 0;
  logic [1:0] cmd_op_i = 0;
  logic [7:0] cmd_data_i = 0;
  logic       busy_o, done_o, drive_low_o, line_i;
  logic [7:0] rdata_o;

  int n_cmp = 0, n_fail = 0;

  // bus device model
  int   rel_cnt = 1000000, rise_cnt = 0, base = 0, hold_len = 0;
  logic use_pat = 0, drv_d = 0, dev_low;
  logic [7:0] pat = 0;

  always @(posedge clk_i) begin
    if (drive_low_o) rel_cnt <= 0;
    else if (rel_cnt < 1000000) rel_cnt <= rel_cnt + 1;
    drv_d <= drive_low_o;
    if (drive_low_o && !drv_d) rise_cnt <= rise_cnt + 1;
  end

  always_comb begin
    if (use_pat) dev_low = !pat[(rise_cnt - base - 1) & 7] && (rel_cnt < 30);
    else         dev_low = rel_cnt < hold_len;
  end
  assign line_i = ~(drive_low_o | dev_low);

  owire_slot_master #(.CLK_DIV(DIV)) i_owire_slot_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .coef_i(coef_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_data_i(cmd_data_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .line_i(line_i), .drive_low_o(drive_low_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int busy_n, low_n, pulses, rd, done_after;
  int widths[8];

  // issue a command, measure it; optionally present a second command mid-slot
  task automatic run(logic [1:0] op, logic [7:0] data, int inject_at);
    int cur_w;
    base = rise_cnt;
    @(negedge clk_i);
    cmd_valid_i = 1; cmd_op_i = op; cmd_data_i = data;
    @(negedge clk_i);
    cmd_valid_i = 0;
    busy_n = 0; low_n = 0; pulses = 0; cur_w = 0;
    for (int k = 0; k < 8; k++) widths[k] = 0;
    for (int i = 0; i < 40000; i++) begin
      if (done_o) break;
      if (i == inject_at) begin cmd_valid_i = 1; cmd_op_i = 2'b10; end
      else cmd_valid_i = 0;
      if (busy_o) busy_n++;
      if (drive_low_o) begin
        low_n++; cur_w++;
      end else if (cur_w != 0) begin
        if (pulses < 8) widths[pulses] = cur_w;
        pulses++; cur_w = 0;
      end
      @(negedge clk_i);
    end
    cmd_valid_i = 0;
    rd = rdata_o;
    @(negedge clk_i);
    done_after = done_o;
  endtask

  task automatic t_reset_state;
    chk("R8 busy", busy_o, 0);
    chk("R8 done", done_o, 0);
    chk("R8 drive", drive_low_o, 0);
    chk("R8 rdata", rdata_o, 0);
  endtask

  task automatic t_write1;
    hold_len = 0; coef_i = 1;
    run(2'b00, 8'h01, -1);
    chk("R1 low", low_n, 6*DIV);
    chk("R1 busy", busy_n, 70*DIV + 1);
    chk("R1 rdata", rd, 1);
    chk("R7 done pulse", done_after, 0);
  endtask

  task automatic t_write0;
    hold_len = 0; coef_i = 1;
    run(2'b00, 8'h00, -1);
    chk("R2 low", low_n, 60*DIV);
    chk("R2 busy", busy_n, 70*DIV + 1);
    chk("R2 rdata", rd, 0);
  endtask

  task automatic t_bus_reset;
    hold_len = 160; coef_i = 1;
    run(2'b10, 8'h00, -1);
    chk("R3 low", low_n, 480*DIV);
    chk("R3 busy", busy_n, 960*DIV + 1);
    chk("R3 presence", rd, 0);
    hold_len = 0;
    run(2'b11, 8'h00, -1);
    chk("R3 absent", rd, 1);
  endtask

  task automatic t_sample_point;
    coef_i = 1;
    hold_len = 9*DIV - 4;
    run(2'b00, 8'h01, -1);
    chk("R4 early release", rd, 1);
    hold_len = 9*DIV + 4;
    run(2'b00, 8'h01, -1);
    chk("R4 late release", rd, 0);
    hold_len = 0;
  endtask

  task automatic t_byte_write;
    logic [7:0] d;
    d = 8'hA5; hold_len = 0; coef_i = 1;
    run(2'b01, d, -1);
    chk("R5 busy", busy_n, 8*(70*DIV + 1));
    chk("R5 pulses", pulses, 8);
    for (int k = 0; k < 8; k++) chk("R5 width lsb-first", widths[k], d[k] ? 6*DIV : 60*DIV);
    chk("R5 rdata", rd, d);
  endtask

  task automatic t_byte_read;
    coef_i = 1; pat = 8'h3C; use_pat = 1;
    run(2'b01, 8'hFF, -1);
    use_pat = 0;
    chk("R5 read byte", rd, 8'h3C);
  endtask

  task automatic t_coef;
    hold_len = 0;
    coef_i = 3;
    run(2'b00, 8'h01, -1);
    chk("R6 coef3 low", low_n, 6*DIV*3);
    chk("R6 coef3 busy", busy_n, 70*DIV*3 + 1);
    coef_i = 0;
    run(2'b00, 8'h01, -1);
    chk("R6 coef0 busy", busy_n, 70*DIV + 1);
    coef_i = 2;
    fork
      run(2'b00, 8'h00, -1);
      begin repeat (5) @(negedge clk_i); coef_i = 5; end
    join
    chk("R6 midslot low", low_n, 60*DIV*2);
    chk("R6 midslot busy", busy_n, 70*DIV*2 + 1);
    coef_i = 1;
  endtask

  task automatic t_ignore;
    hold_len = 0; coef_i = 1;
    run(2'b00, 8'h00, 10);
    chk("R7 ignored busy", busy_n, 70*DIV + 1);
    chk("R7 ignored low", low_n, 60*DIV);
    chk("R7 ignored rdata", rd, 0);
    repeat (5) @(negedge clk_i);
    chk("R7 idle after", busy_o, 0);
    chk("R9 released idle", drive_low_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset_state();
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    t_reset_state();
    t_write1();
    t_write0();
    t_bus_reset();
    t_sample_point();
    t_byte_write();
    t_byte_read();
    t_coef();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule